// File: doc/BRIEF.md
# SDRAM Mode-Register Write Sequencer

This block sits between a processor's write port and the command pins of two SDRAM areas. A byte-wide write that lands in one of two 4 KiB control windows does not move data. The window picks the SDRAM area, and the low twelve address bits (the offset) carry the value to load into that area's mode register. The write data bus is not connected, because its contents never matter.

On an accepted write the block drives a precharge-all-banks command to the addressed area. It then waits for a programmable precharge time and issues the mode-register-set command, with the offset placed on the SDRAM address pins. The offset is shifted right by two bits for a 32-bit data bus and by one bit for a 16-bit data bus, so that the SDRAM pin A0 matches the processor's lowest word-lane address bit. After a programmable mode-register settle time the block returns a one-cycle ready pulse to the processor.

A write whose CAS latency field is unsupported is acknowledged at once and reaches no SDRAM pin.

Top module: `sdram_modeset_seq`

## Requirements
- R1: A byte write to 0xFFFFD000–0xFFFFDFFF targets area 2. Only sd_cs_n[0] goes low during its commands, and sd_cs_n[1] stays high.
- R2: A byte write to 0xFFFFE000–0xFFFFEFFF targets area 3. Only sd_cs_n[1] goes low during its commands.
- R3: A write starts a sequence only if exactly one of the four cpu_be bits is set and the address is inside a window. Any other write produces no ready pulse and no command.
- R4: In the cycle after the accepting clock edge, the block issues precharge-all for one cycle. In that cycle the addressed chip select, RAS and WE are low, CAS is high, sd_addr bit 10 is 1 and every other sd_addr bit is 0.
- R5: Between the precharge-all cycle and the mode-register-set cycle there are exactly trp_sel+1 cycles with every chip select high.
- R6: The mode-register-set command lasts one cycle, with chip select, RAS, CAS and WE all low. With narrow_bus=0, sd_addr equals the 12-bit offset shifted right by 2.
- R7: With narrow_bus=1, the mode-register-set command drives sd_addr with the 12-bit offset shifted right by 1.
- R8: After the mode-register-set cycle come exactly tmrd_sel+2 cycles with every chip select high. cpu_rdy is then high for exactly one cycle.
- R9: The CAS latency field is offset bits 8:6 when narrow_bus=0 and offset bits 7:5 when narrow_bus=1. A field value of 0 or of 4 to 7 makes cpu_rdy pulse in the cycle after acceptance, and no chip select goes low.
- R10: A write strobe that arrives while a sequence is running is ignored. It causes no extra command and no extra ready pulse.
- R11: After reset and while idle, all chip selects, RAS, CAS and WE are high, sd_addr is 0 and cpu_rdy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 32 | Processor write address |
| cpu_be | input | 4 | Processor byte enables |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_rdy | output | 1 | One-cycle acknowledge |
| narrow_bus | input | 1 | 1 = 16-bit SDRAM data bus, 0 = 32-bit |
| trp_sel | input | 2 | Precharge wait, trp_sel+1 cycles |
| tmrd_sel | input | 2 | Mode settle wait, tmrd_sel+2 cycles |
| sd_cs_n | output | 2 | Chip selects, bit 0 area 2, bit 1 area 3, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 13 | SDRAM address pins |

## Verification
The checker assumes that narrow_bus, trp_sel and tmrd_sel hold still while a sequence runs, because the wait lengths and the pin shift are sampled over several cycles. It also assumes that cpu_wr is a one-cycle strobe. The bench changes these configuration inputs only at a falling edge while the block is idle, and it pulses cpu_wr for exactly one cycle. The one deliberate strobe that arrives mid-sequence exercises the rule that busy strobes are ignored, and it keeps to the same one-cycle form.

// File: rtl/sdms_pkg.sv
package sdms_pkg;
  localparam int OFS_W  = 12;
  localparam int MPIN_W = 12;
  localparam int AP_BIT = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PALL, ST_TRP, ST_MRS, ST_TMRD, ST_ACK
  } seq_state_t;

  typedef enum logic [1:0] {CMD_DESEL, CMD_PALL, CMD_MRS} sd_cmd_t;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_ctl_t;

  // CAS latency field position moves down one bit on the narrow bus
  function automatic logic [2:0] f_cas_field(logic [OFS_W-1:0] ofs, logic narrow);
    logic [OFS_W-1:0] sh;
    sh = narrow ? (ofs >> 5) : (ofs >> 6);
    return sh[2:0];
  endfunction

  function automatic logic f_cas_ok(logic [2:0] cl);
    return (cl >= 3'd1) && (cl <= 3'd3);
  endfunction

  // processor offset to SDRAM pin value
  function automatic logic [MPIN_W-1:0] f_mode_pins(logic [OFS_W-1:0] ofs, logic narrow);
    logic [OFS_W-1:0] sh;
    sh = narrow ? (ofs >> 1) : (ofs >> 2);
    return sh[MPIN_W-1:0];
  endfunction

  function automatic sd_ctl_t f_ctl(sd_cmd_t c);
    sd_ctl_t r;
    case (c)
      CMD_PALL: r = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_MRS:  r = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default:  r = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sdms_decode.sv
module sdms_decode
  import sdms_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4,
  parameter logic [ADDR_W-1:0] WIN_A_BASE = 32'hFFFF_D000,
  parameter logic [ADDR_W-1:0] WIN_B_BASE = 32'hFFFF_E000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic              narrow,
  output logic              hit,
  output logic              area_b,
  output logic              byte_ok,
  output logic              cl_ok,
  output logic [MPIN_W-1:0] mode_pins
);
  localparam int TAG_W = ADDR_W - OFS_W;
  localparam int CNT_W = $clog2(BE_W + 1);

  logic [TAG_W-1:0] tag;
  logic [OFS_W-1:0] ofs;
  logic hit_a, hit_b;
  logic [CNT_W-1:0] lanes;

  assign tag   = addr[ADDR_W-1:OFS_W];
  assign ofs   = addr[OFS_W-1:0];
  assign hit_a = (tag == WIN_A_BASE[ADDR_W-1:OFS_W]);
  assign hit_b = (tag == WIN_B_BASE[ADDR_W-1:OFS_W]);
  assign hit   = hit_a | hit_b;
  assign area_b = hit_b;

  always_comb begin
    lanes = '0;
    for (int i = 0; i < BE_W; i++) lanes = lanes + CNT_W'(be[i]);
  end

  assign byte_ok   = (lanes == CNT_W'(1));
  assign cl_ok     = f_cas_ok(f_cas_field(ofs, narrow));
  assign mode_pins = f_mode_pins(ofs, narrow);
endmodule

// File: rtl/sdms_wait.sv
module sdms_wait #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sdms_cmd_drive.sv
module sdms_cmd_drive
  import sdms_pkg::*;
#(
  parameter int SDA_W  = 13,
  parameter int AREA_N = 2
) (
  input  sd_cmd_t           cmd,
  input  logic              area_b,
  input  logic [MPIN_W-1:0] mode_pins,
  output logic [AREA_N-1:0] cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [SDA_W-1:0]  addr
);
  localparam int PAD_W = SDA_W - MPIN_W;

  sd_ctl_t ctl;
  logic    active;

  assign ctl    = f_ctl(cmd);
  assign active = (cmd != CMD_DESEL);
  assign ras_n  = ctl.ras_n;
  assign cas_n  = ctl.cas_n;
  assign we_n   = ctl.we_n;

  for (genvar g = 0; g < AREA_N; g++) begin : g_cs
    assign cs_n[g] = !(active && (int'(area_b) == g));
  end

  always_comb begin
    addr = '0;
    if (cmd == CMD_PALL)     addr[AP_BIT] = 1'b1;
    else if (cmd == CMD_MRS) addr = {{PAD_W{1'b0}}, mode_pins};
  end
endmodule

// File: rtl/sdram_modeset_seq.sv
module sdram_modeset_seq
  import sdms_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4,
  parameter int SDA_W  = 13,
  parameter int TSEL_W = 2,
  parameter logic [ADDR_W-1:0] WIN_A_BASE = 32'hFFFF_D000,
  parameter logic [ADDR_W-1:0] WIN_B_BASE = 32'hFFFF_E000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BE_W-1:0]   cpu_be,
  input  logic              cpu_wr,
  output logic              cpu_rdy,
  input  logic              narrow_bus,
  input  logic [TSEL_W-1:0] trp_sel,
  input  logic [TSEL_W-1:0] tmrd_sel,
  output logic [1:0]        sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [SDA_W-1:0]  sd_addr
);
  localparam int CNT_W  = TSEL_W + 1;
  localparam int AREA_N = 2;

  seq_state_t        state;
  logic              area_q;
  logic [MPIN_W-1:0] pins_q;

  // named internal events, used by the checker
  logic              win_hit, byte_ok, evt_cl_ok, area_d;
  logic [MPIN_W-1:0] pins_d;
  logic              evt_idle, evt_accept;
  logic              wait_load, wait_done;
  logic [CNT_W-1:0]  wait_val;
  sd_cmd_t           cmd;

  sdms_decode #(
    .ADDR_W(ADDR_W), .BE_W(BE_W),
    .WIN_A_BASE(WIN_A_BASE), .WIN_B_BASE(WIN_B_BASE)
  ) u_decode (
    .addr(cpu_addr), .be(cpu_be), .narrow(narrow_bus),
    .hit(win_hit), .area_b(area_d), .byte_ok(byte_ok),
    .cl_ok(evt_cl_ok), .mode_pins(pins_d)
  );

  assign evt_idle   = (state == ST_IDLE);
  assign evt_accept = evt_idle && cpu_wr && win_hit && byte_ok;

  // one down-counter serves both the precharge and the settle wait
  assign wait_load = (state == ST_PALL) || (state == ST_MRS);
  assign wait_val  = (state == ST_PALL) ? {1'b0, trp_sel}
                                        : ({1'b0, tmrd_sel} + CNT_W'(1));

  sdms_wait #(.CNT_W(CNT_W)) u_wait (
    .clk(clk), .rst(rst), .load(wait_load), .load_val(wait_val), .done(wait_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      area_q <= 1'b0;
      pins_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (evt_accept) begin
          area_q <= area_d;
          pins_q <= pins_d;
          state  <= evt_cl_ok ? ST_PALL : ST_ACK;
        end
        ST_PALL: state <= ST_TRP;
        ST_TRP:  if (wait_done) state <= ST_MRS;
        ST_MRS:  state <= ST_TMRD;
        ST_TMRD: if (wait_done) state <= ST_ACK;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_PALL: cmd = CMD_PALL;
      ST_MRS:  cmd = CMD_MRS;
      default: cmd = CMD_DESEL;
    endcase
  end

  assign cpu_rdy = (state == ST_ACK);

  sdms_cmd_drive #(.SDA_W(SDA_W), .AREA_N(AREA_N)) u_drive (
    .cmd(cmd), .area_b(area_q), .mode_pins(pins_q),
    .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .addr(sd_addr)
  );
endmodule

// File: rtl/sdram_modeset_seq_chk.sv
module sdram_modeset_seq_chk #(
  parameter int SDA_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_wr,
  input logic             cpu_rdy,
  input logic [1:0]       sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [SDA_W-1:0] sd_addr,
  input logic             evt_idle,
  input logic             evt_accept,
  input logic             evt_cl_ok,
  input logic             win_hit,
  input logic             byte_ok
);
  logic any_cs, is_mrs;
  assign any_cs = !(&sd_cs_n);
  assign is_mrs = any_cs && !sd_ras_n && !sd_cas_n && !sd_we_n;

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    evt_idle |-> (!any_cs && !cpu_rdy && sd_addr == '0));

  a_r1_one_cs: assert property (@(posedge clk) disable iff (rst)
    $countones(~sd_cs_n) <= 1);

  a_r4_pall_first: assert property (@(posedge clk) disable iff (rst)
    (evt_accept && evt_cl_ok) |=> (any_cs && !sd_ras_n && sd_cas_n && !sd_we_n && sd_addr[10]));

  a_r5_gap_before_mrs: assert property (@(posedge clk) disable iff (rst)
    is_mrs |-> $past(&sd_cs_n));

  a_r6_mrs_single: assert property (@(posedge clk) disable iff (rst)
    is_mrs |=> !any_cs);

  a_r8_rdy_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_rdy |=> !cpu_rdy);

  a_r9_bad_cl_ack: assert property (@(posedge clk) disable iff (rst)
    (evt_accept && !evt_cl_ok) |=> (cpu_rdy && !any_cs));

  a_r3_reject: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && evt_idle && !(win_hit && byte_ok)) |=> (!cpu_rdy && !any_cs));
endmodule

bind sdram_modeset_seq sdram_modeset_seq_chk #(.SDA_W(SDA_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rdy(cpu_rdy),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_addr(sd_addr), .evt_idle(evt_idle), .evt_accept(evt_accept),
  .evt_cl_ok(evt_cl_ok), .win_hit(win_hit), .byte_ok(byte_ok)
);

// File: tb/sdram_modeset_seq_tb.sv
module sdram_modeset_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cpu_addr = '0;
  logic [3:0]  cpu_be = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rdy;
  logic        narrow_bus = 1'b0;
  logic [1:0]  trp_sel = '0;
  logic [1:0]  tmrd_sel = '0;
  logic [1:0]  sd_cs_n;
  logic        sd_ras_n, sd_cas_n, sd_we_n;
  logic [12:0] sd_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // observations from the last write
  int k_pall, k_mrs, k_rdy, n_pall, n_mrs, n_rdy, n_other;
  int cs_pall, cs_mrs, a_pall, a_mrs;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_modeset_seq dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wr(cpu_wr),
    .cpu_rdy(cpu_rdy), .narrow_bus(narrow_bus), .trp_sel(trp_sel), .tmrd_sel(tmrd_sel),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive one write strobe and watch the pins for 24 cycles
  task automatic run_write(input logic [31:0] a, input logic [3:0] be, input logic nb,
                           input logic [1:0] trp, input logic [1:0] tmrd, input bit inject);
    @(negedge clk);
    narrow_bus = nb; trp_sel = trp; tmrd_sel = tmrd;
    cpu_addr = a; cpu_be = be; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    k_pall = -1; k_mrs = -1; k_rdy = -1;
    n_pall = 0; n_mrs = 0; n_rdy = 0; n_other = 0;
    cs_pall = 3; cs_mrs = 3; a_pall = -1; a_mrs = -1;
    for (int k = 1; k <= 24; k++) begin
      if (sd_cs_n != 2'b11) begin
        if (!sd_ras_n && sd_cas_n && !sd_we_n) begin
          n_pall++; k_pall = k; cs_pall = int'(sd_cs_n); a_pall = int'(sd_addr);
        end else if (!sd_ras_n && !sd_cas_n && !sd_we_n) begin
          n_mrs++; k_mrs = k; cs_mrs = int'(sd_cs_n); a_mrs = int'(sd_addr);
        end else n_other++;
      end
      if (cpu_rdy) begin n_rdy++; k_rdy = k; end
      if (inject && k == 2) begin
        cpu_addr = 32'hFFFF_E8C0; cpu_be = 4'b0001; cpu_wr = 1'b1;
      end else cpu_wr = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(sd_cs_n == 2'b11 && sd_ras_n && sd_cas_n && sd_we_n, "R11 pins idle", int'(sd_cs_n), 3);
    chk(sd_addr == 13'd0, "R11 addr zero", int'(sd_addr), 0);
    chk(cpu_rdy == 1'b0, "R11 rdy low", int'(cpu_rdy), 0);
  endtask

  task automatic t_good(input logic [31:0] a, input logic nb, input logic [1:0] trp,
                        input logic [1:0] tmrd, input bit inject);
    int ofs, exp_pins, exp_cs;
    ofs      = int'(a) & 4095;
    exp_pins = nb ? ofs / 2 : ofs / 4;
    exp_cs   = (a[15:12] == 4'hE) ? 1 : 2;
    run_write(a, 4'b0100, nb, trp, tmrd, inject);
    chk(n_pall == 1 && k_pall == 1, "R4 pall cycle", k_pall, 1);
    chk(a_pall == 32'h400, "R4 pall addr", a_pall, 32'h400);
    chk(cs_pall == exp_cs, exp_cs == 2 ? "R1 pall cs" : "R2 pall cs", cs_pall, exp_cs);
    chk(n_mrs == 1 && (k_mrs - k_pall - 1) == int'(trp) + 1, "R5 trp gap",
        k_mrs - k_pall - 1, int'(trp) + 1);
    chk(a_mrs == exp_pins, nb ? "R7 narrow mrs addr" : "R6 wide mrs addr", a_mrs, exp_pins);
    chk(cs_mrs == exp_cs, exp_cs == 2 ? "R1 mrs cs" : "R2 mrs cs", cs_mrs, exp_cs);
    chk(n_rdy == 1 && (k_rdy - k_mrs - 1) == int'(tmrd) + 2, "R8 settle gap",
        k_rdy - k_mrs - 1, int'(tmrd) + 2);
    chk(n_other == 0, inject ? "R10 no extra cmd" : "R6 no stray cmd", n_other, 0);
    if (inject) chk(n_pall == 1 && n_mrs == 1 && n_rdy == 1, "R10 busy strobe ignored",
                    n_pall + n_mrs + n_rdy, 3);
  endtask

  task automatic t_bad_cl(input logic [31:0] a, input logic nb);
    run_write(a, 4'b0001, nb, 2'd1, 2'd1, 1'b0);
    chk(n_rdy == 1 && k_rdy == 1, "R9 bad CL ack", k_rdy, 1);
    chk(n_pall + n_mrs + n_other == 0, "R9 bad CL no cmd", n_pall + n_mrs + n_other, 0);
  endtask

  task automatic t_reject(input logic [31:0] a, input logic [3:0] be);
    run_write(a, be, 1'b0, 2'd0, 2'd0, 1'b0);
    chk(n_rdy == 0, "R3 no ready", n_rdy, 0);
    chk(n_pall + n_mrs + n_other == 0, "R3 no cmd", n_pall + n_mrs + n_other, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_good(32'hFFFF_D880, 1'b0, 2'd0, 2'd0, 1'b0);
    t_good(32'hFFFF_E8C0, 1'b0, 2'd3, 2'd3, 1'b0);
    t_good(32'hFFFF_E840, 1'b0, 2'd2, 2'd1, 1'b0);
    t_good(32'hFFFF_D420, 1'b1, 2'd1, 2'd2, 1'b0);
    t_good(32'hFFFF_E460, 1'b1, 2'd0, 2'd3, 1'b0);
    t_bad_cl(32'hFFFF_D800, 1'b0);
    t_bad_cl(32'hFFFF_E9C0, 1'b0);
    t_bad_cl(32'hFFFF_D480, 1'b1);
    t_reject(32'hFFFF_D880, 4'b0011);
    t_reject(32'hFFFF_E880, 4'b0000);
    t_reject(32'hFFFF_C880, 4'b0001);
    t_good(32'hFFFF_D880, 1'b0, 2'd1, 2'd0, 1'b1);
    t_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule